// File: doc/BRIEF.md
# I2C-over-AUX EDID Reply Engine

This block stands in for a display auxiliary-channel controller whose only job is to let host software read a monitor's identification ROM (EDID) through I2C transactions carried over the channel. The host sees a small register window: one control word at offset 0x10 and five data words at 0x14, 0x18, 0x1C, 0x20 and 0x24. Only bits 7:0 of the offset are decoded.

To issue a request, the host first stores a request word in the first data register and then writes the control register with bit 31 (send-busy) set. In the next cycle the block has decoded the request and updated its I2C target state. It has also rewritten both the control word and the first data word with a finished reply. Address-only requests select or release the ROM target. One-byte reads return the next ROM byte from an internal pointer. The ROM itself lives outside the block, which presents the pointer on `rom_idx` and takes the addressed byte on `rom_byte`.

Top module: `aux_edid_reply`

## Requirements
- R1: Writes to offsets 0x14, 0x18, 0x1C, 0x20 and 0x24 are stored and read back unchanged on `rd_data`. Writes to any other offset except 0x10 change no register, and reading such an offset returns 0.
- R2: A write to offset 0x10 with bit 31 clear changes no register and no target state.
- R3: A write to offset 0x10 with bit 31 set is a send. One cycle later the control word reads as bit 30 (done) plus a reply size in bits 24:20, with every other bit clear. The reply size is 2 when opcode bit 0 is set and 1 otherwise. The opcode is bits 31:28 of data word 1, and opcode bit 0 (data bit 28) marks a read.
- R4: A send whose length (bits 24:20 of the control write) is 3 and whose opcode bit 2 (data bit 30, middle-of-transaction) is clear acts as a stop. It deselects the target, clears availability and returns the pointer to 0.
- R5: A length-3 send with bit 30 set does one of three things, depending on the address in data bits 23:8. Address 0 resets the state as in R4. Address 0x50 selects the ROM target and marks the ROM available if `sink_ok` is high; availability stays set once set. Any other address leaves the state unchanged.
- R6: A read send of length 4, with the target selected and the ROM available, returns the byte at the pointer in data bits 23:16 and advances the pointer by one.
- R7: A read send of length 4 with no target selected, or with the ROM unavailable, returns 0xFF in bits 23:16 and leaves the pointer where it is.
- R8: Once the pointer reaches `ROM_BYTES`, further reads return 0x00 and the pointer stays at `ROM_BYTES`.
- R9: Every reply that writes data word 1 sets it to the ACK code 0x00 in bits 31:24, the read byte (if any) in bits 23:16, and zeros elsewhere. A non-read send of any length other than 3 is acknowledged this way and nothing else happens.
- R10: A read send whose length is neither 3 nor 4 leaves data word 1 and the target state unchanged. Only the control word is updated, as in R3.
- R11: After reset, all six registers read 0, no target is selected and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read offset |
| rd_data | output | 32 | Register read data (combinational) |
| sink_ok | input | 1 | A display that can serve the ROM is attached to this port |
| rom_idx | output | PTR_W | Current ROM byte pointer |
| rom_byte | input | 8 | ROM byte at `rom_idx` |

## Verification
The bench drives a ROM of eight bytes through to exhaustion. A pointer that wrapped, or kept counting past the end, would return early bytes again instead of 0x00. It reads before any selection, after a stop, after an address-0 reset and after a selection made while `sink_ok` was low. An engine that ignored the selection or availability gates would return ROM bytes there instead of 0xFF. Sends of a foreign address with the middle bit set, reads of odd length and control writes without the busy bit are checked for leaving the pointer and data word 1 alone. Writes, reads and address-only requests are each checked for the reply size their opcode calls for.

// File: rtl/aux_edid_pkg.sv
package aux_edid_pkg;

    localparam logic [7:0] OFS_CTL = 8'h10;
    localparam int NUM_REGS = 6;

    localparam int BUSY_BIT  = 31;
    localparam int DONE_BIT  = 30;
    localparam int SIZE_LSB  = 20;
    localparam int SIZE_W    = 5;

    localparam logic [3:0]  OP_MOT     = 4'h4;
    localparam logic [7:0]  ACK_CODE   = 8'h00;
    localparam logic [15:0] ROM_TARGET = 16'h0050;
    localparam logic [SIZE_W-1:0] LEN_ADDR_ONLY = 5'd3;
    localparam logic [SIZE_W-1:0] LEN_ONE_READ  = 5'd4;

    typedef enum logic [2:0] {
        SEL_CTL = 3'd0,
        SEL_D1  = 3'd1,
        SEL_D2  = 3'd2,
        SEL_D3  = 3'd3,
        SEL_D4  = 3'd4,
        SEL_D5  = 3'd5,
        SEL_NONE = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic              send;
        logic [SIZE_W-1:0] len;
        logic              is_read;
        logic              mot;
        logic [15:0]       addr;
    } aux_req_t;

    function automatic reg_sel_e map_offset(input logic [7:0] ofs);
        case (ofs)
            8'h10:   return SEL_CTL;
            8'h14:   return SEL_D1;
            8'h18:   return SEL_D2;
            8'h1C:   return SEL_D3;
            8'h20:   return SEL_D4;
            8'h24:   return SEL_D5;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/aux_req_decode.sv
module aux_req_decode
    import aux_edid_pkg::*;
(
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [31:0] wr_data,
    input  logic [31:0] data1_q,
    output aux_req_t    req,
    output logic        store_en,
    output reg_sel_e    store_sel
);

    reg_sel_e sel;
    logic [3:0] opcode;

    always_comb begin
        sel    = map_offset(wr_addr);
        opcode = data1_q[31:28];

        req.send    = wr_en && (sel == SEL_CTL) && wr_data[BUSY_BIT];
        req.len     = wr_data[SIZE_LSB +: SIZE_W];
        req.is_read = opcode[0];
        req.mot     = (opcode & OP_MOT) != 4'h0;
        req.addr    = data1_q[23:8];

        store_en  = wr_en && (sel != SEL_CTL) && (sel != SEL_NONE);
        store_sel = sel;
    end

endmodule

// File: rtl/edid_target_state.sv
module edid_target_state
    import aux_edid_pkg::*;
#(
    parameter int ROM_BYTES = 128,
    parameter int PTR_W     = $clog2(ROM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  aux_req_t         req,
    input  logic             sink_ok,
    input  logic [7:0]       rom_byte,
    output logic [PTR_W-1:0] rom_idx,
    output logic             tgt_sel,
    output logic             data1_upd,
    output logic [31:0]      data1_new
);

    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(ROM_BYTES);

    logic             avail;
    logic [PTR_W-1:0] ptr;
    logic             can_serve;
    logic             in_range;
    logic             addr_only;
    logic             read_one;
    logic             fetch;

    always_comb begin
        can_serve = avail && tgt_sel;
        in_range  = ptr < PTR_END;
        addr_only = req.send && (req.len == LEN_ADDR_ONLY);
        read_one  = req.send && !addr_only && req.is_read && (req.len == LEN_ONE_READ);
        fetch     = read_one && can_serve && in_range;

        data1_upd = 1'b0;
        data1_new = {ACK_CODE, 24'h0};
        if (addr_only) begin
            data1_upd = 1'b1;
        end else if (req.send && !req.is_read) begin
            data1_upd = 1'b1;
        end else if (read_one) begin
            data1_upd = 1'b1;
            if (!can_serve)
                data1_new[23:16] = 8'hFF;
            else if (in_range)
                data1_new[23:16] = rom_byte;
            else
                data1_new[23:16] = 8'h00;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_sel <= 1'b0;
            avail   <= 1'b0;
            ptr     <= '0;
        end else if (addr_only) begin
            if (!req.mot || (req.addr == 16'h0)) begin
                tgt_sel <= 1'b0;
                avail   <= 1'b0;
                ptr     <= '0;
            end else if (req.addr == ROM_TARGET) begin
                tgt_sel <= 1'b1;
                avail   <= avail | sink_ok;
            end
        end else if (fetch) begin
            ptr <= ptr + 1'b1;
        end
    end

    assign rom_idx = ptr;

endmodule

// File: rtl/aux_reg_bank.sv
module aux_reg_bank
    import aux_edid_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        store_en,
    input  reg_sel_e    store_sel,
    input  logic [31:0] store_data,
    input  logic        ctl_upd,
    input  logic [31:0] ctl_new,
    input  logic        data1_upd,
    input  logic [31:0] data1_new,
    input  logic [7:0]  rd_addr,
    output logic [31:0] rd_data,
    output logic [31:0] ctl_q,
    output logic [31:0] data1_q
);

    logic [31:0] regs [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (i == 0) begin : g_ctl
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (ctl_upd)
                    regs[i] <= ctl_new;
            end
        end else if (i == 1) begin : g_d1
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (data1_upd)
                    regs[i] <= data1_new;
                else if (store_en && (int'(store_sel) == i))
                    regs[i] <= store_data;
            end
        end else begin : g_plain
            always_ff @(posedge clk) begin
                if (rst)
                    regs[i] <= '0;
                else if (store_en && (int'(store_sel) == i))
                    regs[i] <= store_data;
            end
        end
    end

    reg_sel_e rsel;

    always_comb begin
        rsel = map_offset(rd_addr);
        if (rsel == SEL_NONE)
            rd_data = '0;
        else
            rd_data = regs[int'(rsel)];
    end

    assign ctl_q   = regs[0];
    assign data1_q = regs[1];

endmodule

// File: rtl/aux_edid_reply.sv
module aux_edid_reply
    import aux_edid_pkg::*;
#(
    parameter int ROM_BYTES = 128,
    localparam int PTR_W    = $clog2(ROM_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_addr,
    input  logic [31:0]      wr_data,
    input  logic [7:0]       rd_addr,
    output logic [31:0]      rd_data,
    input  logic             sink_ok,
    output logic [PTR_W-1:0] rom_idx,
    input  logic [7:0]       rom_byte
);

    aux_req_t    req;
    logic        store_en;
    reg_sel_e    store_sel;
    logic [31:0] ctl_q;
    logic [31:0] data1_q;
    logic [31:0] ctl_new;
    logic        data1_upd;
    logic [31:0] data1_new;
    logic        tgt_sel;

    aux_req_decode u_dec (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .data1_q   (data1_q),
        .req       (req),
        .store_en  (store_en),
        .store_sel (store_sel)
    );

    edid_target_state #(
        .ROM_BYTES (ROM_BYTES),
        .PTR_W     (PTR_W)
    ) u_state (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .sink_ok   (sink_ok),
        .rom_byte  (rom_byte),
        .rom_idx   (rom_idx),
        .tgt_sel   (tgt_sel),
        .data1_upd (data1_upd),
        .data1_new (data1_new)
    );

    always_comb begin
        ctl_new = '0;
        ctl_new[DONE_BIT] = 1'b1;
        ctl_new[SIZE_LSB +: SIZE_W] = req.is_read ? SIZE_W'(2) : SIZE_W'(1);
    end

    aux_reg_bank u_bank (
        .clk        (clk),
        .rst        (rst),
        .store_en   (store_en),
        .store_sel  (store_sel),
        .store_data (wr_data),
        .ctl_upd    (req.send),
        .ctl_new    (ctl_new),
        .data1_upd  (data1_upd),
        .data1_new  (data1_new),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .ctl_q      (ctl_q),
        .data1_q    (data1_q)
    );

endmodule

// File: rtl/aux_edid_reply_chk.sv
module aux_edid_reply_chk #(
    parameter int ROM_BYTES = 128,
    localparam int PTR_W    = $clog2(ROM_BYTES + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [7:0]       wr_addr,
    input logic [31:0]      wr_data,
    input logic [31:0]      ctl_q,
    input logic [31:0]      data1_q,
    input logic             tgt_sel,
    input logic [PTR_W-1:0] rom_idx
);

    logic ctl_hit;
    logic send;
    logic [4:0] len;

    assign ctl_hit = wr_en && (wr_addr == 8'h10);
    assign send    = ctl_hit && wr_data[31];
    assign len     = wr_data[24:20];

    // R3
    done_size_chk: assert property (@(posedge clk) disable iff (rst)
        send |=> ctl_q[30] && (ctl_q[24:20] == ($past(data1_q[28]) ? 5'd2 : 5'd1)));

    // R2
    idle_ctl_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && !wr_data[31]) |=> $stable(ctl_q));

    // R4
    stop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (send && len == 5'd3 && !data1_q[30]) |=> (!tgt_sel && rom_idx == '0));

    // R10
    odd_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (send && data1_q[28] && len != 5'd3 && len != 5'd4) |=> $stable(data1_q));

    // R9
    write_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (send && !data1_q[28]) |=> (data1_q == 32'h0));

    // R8
    ptr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rom_idx <= PTR_W'(ROM_BYTES));

endmodule

bind aux_edid_reply aux_edid_reply_chk #(.ROM_BYTES(ROM_BYTES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctl_q   (ctl_q),
    .data1_q (data1_q),
    .tgt_sel (tgt_sel),
    .rom_idx (rom_idx)
);

// File: tb/aux_edid_reply_bench.sv
module aux_edid_reply_bench;

    localparam int ROM_N = 8;
    localparam int PW    = $clog2(ROM_N + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [7:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [7:0]    rd_addr = '0;
    logic [31:0]   rd_data;
    logic          sink_ok = 1'b0;
    logic [PW-1:0] rom_idx;
    logic [7:0]    rom_byte;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    function automatic logic [7:0] rom_val(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    assign rom_byte = rom_val(int'(rom_idx));

    aux_edid_reply #(.ROM_BYTES(ROM_N)) u_aux_edid_reply (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .sink_ok  (sink_ok),
        .rom_idx  (rom_idx),
        .rom_byte (rom_byte)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    // request word: opcode in bits 31:28, address in 23:8
    task automatic send(input logic [3:0] op, input logic [15:0] addr, input logic [4:0] len);
        wr(8'h14, {op, 4'h0, addr, 8'h00});
        wr(8'h10, (32'h1 << 31) | (32'(len) << 20));
    endtask

    function automatic logic [31:0] ctl_exp(input logic rd);
        return (32'h1 << 30) | ((rd ? 32'd2 : 32'd1) << 20);
    endfunction

    initial begin
        #4000000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        for (int i = 0; i < 6; i++) begin
            rd(8'(8'h10 + 4 * i), v);
            chk("R11 reg after reset", v, 32'h0);
        end
        chk("R11 pointer after reset", 32'(rom_idx), 32'h0);

        // R1 plain data registers and foreign offsets
        for (int i = 1; i < 6; i++) wr(8'(8'h10 + 4 * i), 32'hA500_0000 + 32'(i * 17));
        for (int i = 1; i < 6; i++) begin
            rd(8'(8'h10 + 4 * i), v);
            chk("R1 data readback", v, 32'hA500_0000 + 32'(i * 17));
        end
        wr(8'h28, 32'hDEAD_BEEF);
        wr(8'h00, 32'hDEAD_BEEF);
        wr(8'h11, 32'hDEAD_BEEF);
        for (int i = 0; i < 6; i++) begin
            rd(8'(8'h10 + 4 * i), v);
            chk("R1 unchanged after foreign write", v, (i == 0) ? 32'h0 : 32'hA500_0000 + 32'(i * 17));
        end
        rd(8'h28, v);
        chk("R1 foreign read returns 0", v, 32'h0);

        // R2 control write without busy
        wr(8'h10, 32'h7FFF_FFFF);
        rd(8'h10, v); chk("R2 ctl unchanged", v, 32'h0);
        rd(8'h14, v); chk("R2 data1 unchanged", v, 32'hA500_0011);

        // R7 read before any selection
        sink_ok = 1'b1;
        send(4'h1, 16'h0, 5'd4);
        rd(8'h10, v); chk("R3 ctl after read send", v, ctl_exp(1'b1));
        rd(8'h14, v); chk("R7 unselected read gives FF", v, 32'h00FF_0000);
        chk("R7 pointer held", 32'(rom_idx), 32'h0);

        // R5 select ROM target
        send(4'h5, 16'h0050, 5'd3);
        rd(8'h10, v); chk("R3 ctl after address-only read-op", v, ctl_exp(1'b1));
        rd(8'h14, v); chk("R5 address-only ack", v, 32'h0);

        // R6 / R8 read through to exhaustion
        for (int i = 0; i < ROM_N + 3; i++) begin
            send(4'h1, 16'h0, 5'd4);
            rd(8'h14, v);
            chk("R6 R8 read byte", v, {8'h00, (i < ROM_N) ? rom_val(i) : 8'h00, 16'h0});
            chk("R8 pointer", 32'(rom_idx), 32'((i < ROM_N) ? i + 1 : ROM_N));
        end

        // R10 read of odd length
        wr(8'h14, 32'h1012_3456);
        wr(8'h10, (32'h1 << 31) | (32'd2 << 20));
        rd(8'h14, v); chk("R10 data1 unchanged", v, 32'h1012_3456);
        rd(8'h10, v); chk("R10 ctl updated", v, ctl_exp(1'b1));
        chk("R10 pointer unchanged", 32'(rom_idx), 32'(ROM_N));

        // R4 stop
        send(4'h1, 16'h0050, 5'd3);
        chk("R4 pointer reset by stop", 32'(rom_idx), 32'h0);
        send(4'h1, 16'h0, 5'd4);
        rd(8'h14, v); chk("R4 read after stop gives FF", v, 32'h00FF_0000);

        // R5 select with sink absent
        sink_ok = 1'b0;
        send(4'h5, 16'h0050, 5'd3);
        send(4'h1, 16'h0, 5'd4);
        rd(8'h14, v); chk("R5 unavailable read gives FF", v, 32'h00FF_0000);
        chk("R5 pointer held when unavailable", 32'(rom_idx), 32'h0);

        // R5 availability sticks; foreign address ignored; address 0 resets
        sink_ok = 1'b1;
        send(4'h5, 16'h0050, 5'd3);
        sink_ok = 1'b0;
        send(4'h1, 16'h0, 5'd4);
        rd(8'h14, v); chk("R5 byte 0 after select", v, {8'h00, rom_val(0), 16'h0});
        send(4'h4, 16'h003A, 5'd3);
        chk("R5 foreign address keeps pointer", 32'(rom_idx), 32'h1);
        send(4'h1, 16'h0, 5'd4);
        rd(8'h14, v); chk("R5 byte 1 after foreign address", v, {8'h00, rom_val(1), 16'h0});
        send(4'h4, 16'h0000, 5'd3);
        rd(8'h10, v); chk("R3 ctl after address-only write-op", v, ctl_exp(1'b0));
        chk("R5 address 0 resets pointer", 32'(rom_idx), 32'h0);
        send(4'h1, 16'h0, 5'd4);
        rd(8'h14, v); chk("R5 read after address 0 gives FF", v, 32'h00FF_0000);

        // R9 write request acknowledged only
        send(4'h0, 16'hBEEF, 5'd5);
        rd(8'h14, v); chk("R9 write ack data1", v, 32'h0);
        rd(8'h10, v); chk("R9 write ctl size 1", v, ctl_exp(1'b0));
        rd(8'h18, v); chk("R9 data2 untouched", v, 32'hA500_0022);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule